// File: doc/BRIEF.md
# Path Parity Monitor with Return Status

This block watches the byte stream of a path payload envelope. Two strobes mark the stream: an envelope-valid strobe for each payload byte and a frame-start strobe on the first byte of each envelope. The block folds every valid byte of one envelope into an even-parity 8-bit interleaved code.

During the next envelope, the byte that carries the far end's parity is marked. The block compares that byte with the stored code and reports how many bit columns disagree. It adds that number into a saturating error total, which a management strobe clears. It also assembles the outgoing path status byte from the latest count and a remote-defect code supplied by the caller.

The block also decodes a received path status byte. From it, it produces the far-end error count, the remote-defect code and an enhanced-form flag.

A small controller sequences the checks. It has four states:
- `S_IDLE`: no frame has started since reset.
- `S_FIRST`: the first envelope is being folded, so there is no stored code yet.
- `S_CHECK`: a stored code exists and the parity byte has not yet been seen.
- `S_DONE`: this envelope's parity byte has already been compared.

Its transitions are:
- `S_IDLE` to `S_FIRST` on a frame start.
- `S_FIRST` to `S_CHECK` on a frame start.
- `S_CHECK` to `S_DONE` on a marked parity byte.
- `S_CHECK` to `S_CHECK` on a frame start. This is the missed-parity-byte path.
- `S_DONE` to `S_CHECK` on a frame start.

Top module: `path_parity_mon`

Byte bits are numbered 1 to 8 from the most significant bit (bit 1 = `[7]`, bit 8 = `[0]`).

## Requirements
- R1: The stored code is the XOR of every byte accepted with `env_valid` high, from one frame start up to the byte before the next frame start. It is compared with the byte marked by `b3_mark` in the following envelope. `err_valid` pulses for one cycle on the clock after the marked byte, with `err_cnt` holding the result.
- R2: No comparison is made during the first envelope after reset, because no stored code exists yet.
- R3: `err_cnt` equals the number of bit positions in which the marked byte differs from the stored code. Its range is 0 to 8.
- R4: At most one comparison is made per envelope, and a second marked byte in the same envelope has no effect. If an envelope carries no marked byte, no comparison is made, and its stored code is replaced at the next frame start.
- R5: `err_total` adds each `err_cnt` two clocks after the marked byte. It saturates at 2^ACC_W-1 and never wraps.
- R6: A one-cycle `total_clr` sets `err_total` to zero. It sets it to the count being added in that same cycle, if there is one.
- R7: `g1_out` is formed as follows:
  - `[7:4]` (bits 1 to 4) hold the latest `err_cnt`, which is 0 until the first comparison.
  - `[3:1]` (bits 5 to 7) hold `rdi_in`.
  - `[0]` (bit 8) is 0.
- R8: A byte marked by `g1_mark` is decoded and reported on the next clock with a one-cycle `fe_valid` pulse:
  - `fe_err` is `[7:4]` if that value is 8 or less, and 0 if it is 9 to 15.
  - `fe_rdi` is `[3:1]`.
  - `fe_enh` is 1 when `[2]` differs from `[1]`, that is, when bit 7 is the inverse of bit 6.
- R9: A cycle with `env_valid` low contributes nothing to the code. Any `frame_start`, `b3_mark` or `g1_mark` in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| env_valid | input | 1 | Current byte belongs to the envelope |
| frame_start | input | 1 | Current byte is the first of an envelope |
| b3_mark | input | 1 | Current byte carries the far end's parity |
| g1_mark | input | 1 | Current byte is a received path status byte |
| byte_in | input | 8 | Envelope byte |
| rdi_in | input | 3 | Remote-defect code for the outgoing status byte |
| total_clr | input | 1 | Clear strobe for the error total |
| err_valid | output | 1 | One-cycle pulse: a comparison finished |
| err_cnt | output | 4 | Mismatched bit columns of the latest comparison |
| err_total | output | ACC_W | Saturating sum of error counts |
| g1_out | output | 8 | Outgoing path status byte |
| fe_valid | output | 1 | One-cycle pulse: a status byte was decoded |
| fe_err | output | 4 | Far-end error count |
| fe_rdi | output | 3 | Far-end remote-defect code |
| fe_enh | output | 1 | Remote-defect code is in enhanced form |

## Verification
Parity bytes are driven with several error masks:
- A clean mask separates a correct one-frame lag from an off-by-one-frame comparison.
- Single-bit and eight-bit masks expose a wrong column count.

Some frames include envelope gaps that carry garbage data and stray marks. A wrong fold, or a mark that is not qualified by `env_valid`, shows up as a mismatch one frame later.

Other frames omit the parity byte or repeat it, which tests the one-check-per-envelope rule. A run of eight-bit errors drives the total into saturation.

Received status bytes cover the legal maximum count, an illegal count, and both the plain and enhanced defect forms.

// File: rtl/path_parity_pkg.sv
package path_parity_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam int RDI_W  = 3;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FIRST,
        S_CHECK,
        S_DONE
    } mon_state_e;

    // Number of set bits in one byte (0..8).
    function automatic logic [CNT_W-1:0] bit_errors(input logic [BYTE_W-1:0] v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            n = n + {{(CNT_W-1){1'b0}}, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/parity_fold.sv
module parity_fold
    import path_parity_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              start,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] held
);

    logic [BYTE_W-1:0] run_q;

    // Fold valid bytes; on a frame start, hand the finished code over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            held  <= '0;
        end else if (take) begin
            if (start) begin
                held  <= run_q;
                run_q <= byte_in;
            end else begin
                run_q <= run_q ^ byte_in;
            end
        end
    end

    // R1: the stored code only moves on an accepted frame start
    p_held_at_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(take && start) |-> $stable(held));

endmodule

// File: rtl/check_fsm.sv
module check_fsm
    import path_parity_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mark,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [BYTE_W-1:0] held,
    output logic              err_valid,
    output logic [CNT_W-1:0]  err_cnt
);

    mon_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_FIRST;
            S_FIRST: if (start) state_d = S_CHECK;
            S_CHECK: begin
                if (start)     state_d = S_CHECK;
                else if (mark) state_d = S_DONE;
            end
            S_DONE:  if (start) state_d = S_CHECK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_cnt   <= '0;
        end else begin
            err_valid <= 1'b0;
            if (state_q == S_CHECK && mark && !start) begin
                err_valid <= 1'b1;
                err_cnt   <= bit_errors(held ^ byte_in);
            end
        end
    end

    // R2: a result only follows a cycle spent holding a stored code
    p_needs_prior_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(state_q) == S_CHECK);

    // R4: never two results back to back
    p_single_check_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);

    // R3: count stays within one byte's columns
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> err_cnt <= 4'd8);

endmodule

// File: rtl/sat_total.sv
module sat_total
    import path_parity_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [CNT_W-1:0] add_val,
    input  logic             clr,
    output logic [ACC_W-1:0] total
);

    localparam logic [ACC_W-1:0] TOP = '1;

    logic [ACC_W-1:0] base;
    logic [ACC_W:0]   sum;

    always_comb begin
        base = clr ? '0 : total;
        sum  = {1'b0, base} + {{(ACC_W+1-CNT_W){1'b0}}, add_val};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
        end else if (add_en) begin
            total <= sum[ACC_W] ? TOP : sum[ACC_W-1:0];
        end else begin
            total <= base;
        end
    end

    // R5: without a clear the total never decreases (no wrap)
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> total >= $past(total));

    // R5: a saturated total stays at its ceiling
    p_hold_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(total) == TOP && !$past(clr)) |-> total == TOP);

endmodule

// File: rtl/status_decode.sv
module status_decode
    import path_parity_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mark,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              fe_valid,
    output logic [CNT_W-1:0]  fe_err,
    output logic [RDI_W-1:0]  fe_rdi,
    output logic              fe_enh
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_valid <= 1'b0;
            fe_err   <= '0;
            fe_rdi   <= '0;
            fe_enh   <= 1'b0;
        end else begin
            fe_valid <= mark;
            if (mark) begin
                fe_err <= (byte_in[7:4] > 4'd8) ? '0 : byte_in[7:4];
                fe_rdi <= byte_in[3:1];
                fe_enh <= byte_in[2] ^ byte_in[1];
            end
        end
    end

    // R8: an illegal received count reads as zero
    p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && $past(byte_in[7:4]) > 4'd8) |-> fe_err == 4'd0);

    // R8: reported far-end count is always legal
    p_fe_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fe_valid |-> fe_err <= 4'd8);

endmodule

// File: rtl/path_parity_mon.sv
module path_parity_mon
    import path_parity_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             env_valid,
    input  logic             frame_start,
    input  logic             b3_mark,
    input  logic             g1_mark,
    input  logic [7:0]       byte_in,
    input  logic [2:0]       rdi_in,
    input  logic             total_clr,
    output logic             err_valid,
    output logic [3:0]       err_cnt,
    output logic [ACC_W-1:0] err_total,
    output logic [7:0]       g1_out,
    output logic             fe_valid,
    output logic [3:0]       fe_err,
    output logic [2:0]       fe_rdi,
    output logic             fe_enh
);

    logic              start_q;
    logic              b3_q;
    logic              g1_q;
    logic [BYTE_W-1:0] held;

    // Strobes count only on envelope bytes.
    assign start_q = env_valid & frame_start;
    assign b3_q    = env_valid & b3_mark;
    assign g1_q    = env_valid & g1_mark;

    parity_fold u_fold (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (env_valid),
        .start   (start_q),
        .byte_in (byte_in),
        .held    (held)
    );

    check_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_q),
        .mark      (b3_q),
        .byte_in   (byte_in),
        .held      (held),
        .err_valid (err_valid),
        .err_cnt   (err_cnt)
    );

    sat_total #(.ACC_W(ACC_W)) u_total (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (err_valid),
        .add_val (err_cnt),
        .clr     (total_clr),
        .total   (err_total)
    );

    status_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .mark     (g1_q),
        .byte_in  (byte_in),
        .fe_valid (fe_valid),
        .fe_err   (fe_err),
        .fe_rdi   (fe_rdi),
        .fe_enh   (fe_enh)
    );

    assign g1_out = {err_cnt, rdi_in, 1'b0};

    // R7: outgoing count field follows each new result one cycle later
    p_g1_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_valid) |-> g1_out[7:4] == $past(err_cnt, 1) || $stable(err_cnt));

endmodule

// File: tb/path_parity_mon_bench.sv
`timescale 1ns/1ps
module path_parity_mon_bench;

    localparam int ACC_W = 5;
    localparam int TMAX  = (1 << ACC_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic env_valid = 1'b0, frame_start = 1'b0, b3_mark = 1'b0, g1_mark = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic [2:0] rdi_in = 3'b000;
    logic total_clr = 1'b0;
    logic err_valid, fe_valid, fe_enh;
    logic [3:0] err_cnt, fe_err;
    logic [2:0] fe_rdi;
    logic [7:0] g1_out;
    logic [ACC_W-1:0] err_total;

    always #2 clk = ~clk;

    path_parity_mon #(.ACC_W(ACC_W)) u_path_parity_mon (
        .clk(clk), .rst_n(rst_n), .env_valid(env_valid), .frame_start(frame_start),
        .b3_mark(b3_mark), .g1_mark(g1_mark), .byte_in(byte_in), .rdi_in(rdi_in),
        .total_clr(total_clr), .err_valid(err_valid), .err_cnt(err_cnt),
        .err_total(err_total), .g1_out(g1_out), .fe_valid(fe_valid),
        .fe_err(fe_err), .fe_rdi(fe_rdi), .fe_enh(fe_enh)
    );

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    logic [7:0] fe_q[$];
    logic [7:0] prev_par = 8'h00;
    bit prev_ok = 1'b0;
    int exp_total = 0;
    logic [7:0] lfsr = 8'h5B;
    bit finished = 1'b0;

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] next_rand();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        return lfsr;
    endfunction

    // Scoreboard monitors: compare results as the design produces them.
    always @(negedge clk) begin
        if (rst_n && err_valid) begin
            if (exp_q.size() == 0) begin
                check_val("R2/R4 unexpected comparison", 1, 0);
            end else begin
                check_val("R3 error count", int'(err_cnt), exp_q.pop_front());
            end
        end
        if (rst_n && fe_valid) begin
            if (fe_q.size() == 0) begin
                check_val("R9 unexpected status decode", 1, 0);
            end else begin
                check_val("R8 status decode", int'({fe_err, fe_rdi, fe_enh}), int'(fe_q.pop_front()));
            end
        end
    end

    // Driver: one envelope; parity byte at index 3, status byte at index 4.
    task automatic send_frame(input int nbytes, input bit has_b3, input logic [7:0] mask,
                              input bit dup_b3, input bit gap, input bit has_g1,
                              input logic [7:0] g1v);
        logic [7:0] par;
        logic [7:0] b;
        logic [3:0] e;
        par = 8'h00;
        for (int i = 0; i < nbytes; i++) begin
            if (gap && i == 2) begin
                @(negedge clk);
                env_valid = 1'b0; frame_start = 1'b1; b3_mark = 1'b1; g1_mark = 1'b1;
                byte_in = 8'hFF;
            end
            @(negedge clk);
            env_valid = 1'b1; frame_start = (i == 0); b3_mark = 1'b0; g1_mark = 1'b0;
            if (i == 3 && has_b3) begin
                b = prev_par ^ mask;
                b3_mark = 1'b1;
                if (prev_ok) begin
                    exp_q.push_back($countones(mask));
                    exp_total = exp_total + $countones(mask);
                    if (exp_total > TMAX) exp_total = TMAX;
                end
            end else if (i == 4 && has_g1) begin
                b = g1v;
                g1_mark = 1'b1;
                e = (g1v[7:4] > 4'd8) ? 4'd0 : g1v[7:4];
                fe_q.push_back({e, g1v[3:1], g1v[2] ^ g1v[1]});
            end else if (i == 6 && dup_b3) begin
                b = next_rand();
                b3_mark = 1'b1;
            end else begin
                b = next_rand();
            end
            byte_in = b;
            par = par ^ b;
        end
        @(negedge clk);
        env_valid = 1'b0; frame_start = 1'b0; b3_mark = 1'b0; g1_mark = 1'b0;
        byte_in = 8'h00;
        prev_par = par;
        prev_ok = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rdi_in = 3'b101;
        @(negedge clk);
        check_val("R1 reset err_valid", int'(err_valid), 0);
        check_val("R5 reset total", int'(err_total), 0);
        check_val("R7 status byte before any check", int'(g1_out), 8'h0A);
        check_val("R8 reset fe_valid", int'(fe_valid), 0);

        send_frame(10, 1, 8'h00, 0, 0, 0, 8'h00); // R2 first envelope: no check
        send_frame(10, 1, 8'h00, 0, 0, 0, 8'h00); // R1 clean lag
        send_frame(12, 1, 8'h01, 0, 0, 0, 8'h00); // R3 single column
        send_frame(11, 1, 8'hFF, 0, 1, 1, 8'h85); // R3 all columns, R9 gap, R8 count 8
        send_frame(10, 0, 8'h00, 0, 0, 1, 8'hF8); // R4 no parity byte, R8 illegal count
        send_frame(10, 1, 8'h52, 1, 0, 1, 8'h3C); // R4 repeated mark ignored
        idle(3);
        check_val("R5 total after four checks", int'(err_total), exp_total);
        check_val("R7 outgoing status byte", int'(g1_out), 8'h3A);

        total_clr = 1'b1;
        @(negedge clk);
        total_clr = 1'b0;
        exp_total = 0;
        idle(1);
        check_val("R6 total cleared", int'(err_total), 0);

        for (int k = 0; k < 5; k++) send_frame(9, 1, 8'hFF, 0, 0, 0, 8'h00);
        idle(3);
        check_val("R5 total saturates", int'(err_total), TMAX);
        check_val("R5 model saturation", exp_total, TMAX);

        idle(4);
        check_val("R1 all expected comparisons seen", exp_q.size(), 0);
        check_val("R8 all expected decodes seen", fe_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule